// File: doc/BRIEF.md
# Screen Blanking Timeout Timer

This block blanks a video display after a long spell with no keyboard activity. A free-running 16-bit counter advances by a fixed step of two on every 60 Hz tick strobe. When the counter wraps round to exactly zero, the block drops its display-enable output and emits a one-cycle blank-event pulse. Any detected keystroke reloads the counter with 0x0002 and turns the display back on.

A host write port loads the counter directly. Because the counter only ever changes by an even step, a loaded odd value can never reach zero. Writing an odd value therefore switches the timeout off, and it stays off until the next keystroke reloads an even value. From a keystroke reload, 32767 ticks pass before the counter reaches zero, which is roughly nine minutes and six seconds at 60 Hz.

Top module: `scr_timeout`

## Requirements
- R1: After the synchronous active-high reset, the counter holds 0x0002, display-enable is 1 and the blank-event output is 0.
- R2: Each tick with no keystroke and no host write adds 2 to the counter, modulo 2^16.
- R3: Display-enable falls one clock after the counter becomes zero. Starting from 0x0002 with a tick on every cycle, the counter is zero after 32767 ticks, and display-enable is still 1 in that cycle.
- R4: The blank-event output is high for exactly one cycle, in the cycle in which display-enable first reads 0.
- R5: While the display is blanked, display-enable stays 0 until a keystroke arrives. Later returns of the counter to zero raise no further blank-event pulse.
- R6: A keystroke pulse sets the counter to 0x0002 and display-enable to 1 at the next clock. This includes a keystroke that arrives in the same cycle as an expiry.
- R7: A host write sets the counter to the written value at the next clock. After an odd value is written, ticks alone never blank the display. Writing zero blanks the display one clock later.
- R8: When several inputs arrive in one cycle, a keystroke beats a host write, and a host write beats a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per 60 Hz time tick |
| key_i | input | 1 | One-cycle pulse when a keystroke is detected |
| wr_en_i | input | 1 | Host write strobe for the counter |
| wr_data_i | input | 16 | Value loaded into the counter on a host write |
| disp_en_o | output | 1 | 1 = display visible, 0 = blanked |
| blank_evt_o | output | 1 | One-cycle pulse when the display becomes blanked |

## Verification
A directed run ticks on every cycle from a fresh reload for the full 32767 ticks and then checks the exact cycle in which display-enable falls. This separates a correct step size and wrap point from an off-by-one or a wrong step. A second run loads an odd value and ticks for more than a full wrap. The display must stay on, which shows that expiry fires only on exact zero and not on any wrap.

Collision cases drive keystroke, host write and tick in the same cycle, and also a keystroke in the same cycle as an expiry. These expose a wrong priority order. Random traffic then writes values close to the wrap point and mixes in sparse keystrokes, so that repeated expiries, blanked wraps with no second pulse, and restores are all compared cycle by cycle against a model computed in the bench.

// File: rtl/scr_timeout_pkg.sv
package scr_timeout_pkg;
    parameter int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic disp;
        logic evt;
    } tmo_state_t;
endpackage

// File: rtl/scr_timeout_count.sv
// Next counter value: keystroke reload beats host write, host write beats tick step.
module scr_timeout_count
    import scr_timeout_pkg::*;
#(
    parameter cnt_t STEP   = cnt_t'(2),
    parameter cnt_t RELOAD = cnt_t'(2)
) (
    input  cnt_t cnt_q,
    input  logic tick,
    input  logic key,
    input  logic wr_en,
    input  cnt_t wr_data,
    output cnt_t cnt_d
);
    always_comb begin
        if (key)        cnt_d = RELOAD;
        else if (wr_en) cnt_d = wr_data;
        else if (tick)  cnt_d = cnt_q + STEP;
        else            cnt_d = cnt_q;
    end
endmodule

// File: rtl/scr_timeout_expire.sv
// Exact-zero detection, built as a two-level OR tree over nibble groups.
module scr_timeout_expire
    import scr_timeout_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  cnt_t cnt_q,
    output logic at_zero
);
    localparam int NGRP = (CNT_W + GRP_W - 1) / GRP_W;
    localparam int PADW = NGRP * GRP_W;

    logic [PADW-1:0] padded;
    logic [NGRP-1:0] grp_any;

    assign padded = {{(PADW-CNT_W){1'b0}}, cnt_q};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GRP_W +: GRP_W];
    end

    assign at_zero = ~|grp_any;
endmodule

// File: rtl/scr_timeout_blank.sv
// Display-enable and blank-event next values.
module scr_timeout_blank (
    input  logic disp_q,
    input  logic at_zero,
    input  logic key,
    output logic disp_d,
    output logic evt_d
);
    logic enter_blank;

    always_comb begin
        enter_blank = disp_q & at_zero & ~key;
        evt_d       = enter_blank;
        if (key)              disp_d = 1'b1;
        else if (enter_blank) disp_d = 1'b0;
        else                  disp_d = disp_q;
    end
endmodule

// File: rtl/scr_timeout.sv
module scr_timeout
    import scr_timeout_pkg::*;
#(
    parameter cnt_t STEP   = cnt_t'(2),
    parameter cnt_t RELOAD = cnt_t'(2)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             key_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             disp_en_o,
    output logic             blank_evt_o
);
    tmo_state_t st_q, st_d;
    cnt_t       cnt_q;
    cnt_t       cnt_nxt;
    logic       at_zero;
    logic       disp_nxt;
    logic       evt_nxt;

    assign cnt_q = st_q.cnt;

    scr_timeout_count #(.STEP(STEP), .RELOAD(RELOAD)) u_count (
        .cnt_q   (cnt_q),
        .tick    (tick_i),
        .key     (key_i),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .cnt_d   (cnt_nxt)
    );

    scr_timeout_expire #(.GRP_W(4)) u_expire (
        .cnt_q   (cnt_q),
        .at_zero (at_zero)
    );

    scr_timeout_blank u_blank (
        .disp_q  (st_q.disp),
        .at_zero (at_zero),
        .key     (key_i),
        .disp_d  (disp_nxt),
        .evt_d   (evt_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_nxt;
        st_d.disp = disp_nxt;
        st_d.evt  = evt_nxt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt  <= RELOAD;
            st_q.disp <= 1'b1;
            st_q.evt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_en_o   = st_q.disp;
    assign blank_evt_o = st_q.evt;
endmodule

// File: rtl/scr_timeout_chk.sv
module scr_timeout_chk
    import scr_timeout_pkg::*;
#(
    parameter cnt_t STEP   = cnt_t'(2),
    parameter cnt_t RELOAD = cnt_t'(2)
) (
    input logic clk_i,
    input logic rst_i,
    input logic tick_i,
    input logic key_i,
    input logic wr_en_i,
    input cnt_t wr_data_i,
    input logic disp_en_o,
    input logic blank_evt_o,
    input cnt_t cnt_q
);
    p_tick_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !key_i && !wr_en_i) |=> (cnt_q == cnt_t'($past(cnt_q) + STEP)));

    p_fall_evt_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(disp_en_o) |-> blank_evt_o);

    p_evt_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        blank_evt_o |=> !blank_evt_o);

    p_evt_blanked_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        blank_evt_o |-> !disp_en_o);

    p_hold_blank_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!disp_en_o && !key_i) |=> (!disp_en_o && !blank_evt_o));

    p_key_restore_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        key_i |=> (disp_en_o && !blank_evt_o && cnt_q == RELOAD));

    p_host_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !key_i) |=> (cnt_q == $past(wr_data_i)));
endmodule

bind scr_timeout scr_timeout_chk #(.STEP(STEP), .RELOAD(RELOAD)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .key_i       (key_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .disp_en_o   (disp_en_o),
    .blank_evt_o (blank_evt_o),
    .cnt_q       (cnt_q)
);

// File: tb/sim_scr_timeout.sv
`timescale 1ns/1ps
module sim_scr_timeout;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, key = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        disp_en, blank_evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_cnt;
    logic        m_disp, m_evt;

    always #4 clk = ~clk;

    scr_timeout u0 (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .key_i(key),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .disp_en_o(disp_en), .blank_evt_o(blank_evt)
    );

    function automatic logic [15:0] f_cnt(logic [15:0] c, logic t, logic k, logic w, logic [15:0] d);
        if (k)      return 16'h0002;
        else if (w) return d;
        else if (t) return c + 16'd2;
        return c;
    endfunction

    function automatic logic f_enter(logic [15:0] c, logic dsp, logic k);
        return dsp && (c == 16'h0000) && !k;
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, advance the model, compare at the next falling edge.
    task automatic step(logic t, logic k, logic w, logic [15:0] d, string req);
        logic enter;
        tick = t; key = k; wr_en = w; wr_data = d;
        @(negedge clk);
        enter  = f_enter(m_cnt, m_disp, k);
        m_cnt  = f_cnt(m_cnt, t, k, w, d);
        m_evt  = enter;
        m_disp = k ? 1'b1 : (enter ? 1'b0 : m_disp);
        check(req, disp_en, m_disp, "disp_en");
        check(req, blank_evt, m_evt, "blank_evt");
    endtask

    task automatic idle(string req);
        step(1'b0, 1'b0, 1'b0, 16'h0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(180000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = 16'h0002; m_disp = 1'b1; m_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", disp_en, 1'b1, "disp_en after reset");
        check("R1", blank_evt, 1'b0, "blank_evt after reset");

        // R2 R3: full run from reload, ticking every cycle
        for (int i = 0; i < 32767; i++) step(1'b1, 1'b0, 1'b0, 16'h0, "R2");
        check("R3", disp_en, 1'b1, "still on when counter hits zero");
        idle("R3");
        check("R3", disp_en, 1'b0, "falls one cycle after zero");
        check("R4", blank_evt, 1'b1, "pulse on entry");
        idle("R4");
        check("R4", blank_evt, 1'b0, "pulse lasts one cycle");

        // R5: another full wrap while blanked gives no new pulse
        for (int i = 0; i < 32768; i++) step(1'b1, 1'b0, 1'b0, 16'h0, "R5");
        idle("R5");
        check("R5", disp_en, 1'b0, "stays blank over wrap");
        check("R5", blank_evt, 1'b0, "no second pulse");

        // R6: keystroke restores
        step(1'b0, 1'b1, 1'b0, 16'h0, "R6");
        check("R6", disp_en, 1'b1, "key restores display");

        // R7: odd value never expires
        step(1'b0, 1'b0, 1'b1, 16'hFFFB, "R7");
        for (int i = 0; i < 33000; i++) step(1'b1, 1'b0, 1'b0, 16'h0, "R7");
        check("R7", disp_en, 1'b1, "odd load never blanks");
        // R7: writing zero blanks
        step(1'b0, 1'b0, 1'b1, 16'h0000, "R7");
        check("R7", disp_en, 1'b1, "on in the load cycle");
        idle("R7");
        check("R7", disp_en, 1'b0, "zero load blanks next clock");

        // R8: key beats write and tick; write beats tick
        step(1'b1, 1'b1, 1'b1, 16'h0000, "R8");
        idle("R8");
        check("R8", disp_en, 1'b1, "key beat write of zero");
        step(1'b1, 1'b0, 1'b1, 16'hFFFE, "R8");
        step(1'b1, 1'b0, 1'b0, 16'h0, "R8");
        idle("R8");
        check("R8", disp_en, 1'b0, "write beat tick then one tick to zero");

        // R6: keystroke in the same cycle as expiry
        step(1'b0, 1'b1, 1'b0, 16'h0, "R6");
        step(1'b0, 1'b0, 1'b1, 16'h0000, "R6");
        step(1'b1, 1'b1, 1'b0, 16'h0, "R6");
        check("R6", disp_en, 1'b1, "key at expiry keeps display");
        check("R6", blank_evt, 1'b0, "key at expiry no pulse");

        // Random traffic near the wrap point
        for (int i = 0; i < 30000; i++) begin
            logic t, k, w;
            logic [15:0] d;
            string req;
            t = ($urandom % 2) == 0;
            k = ($urandom % 97) == 0;
            w = ($urandom % 40) == 0;
            case ($urandom % 4)
                0: d = 16'h0000;
                1: d = 16'hFFC0 | 16'($urandom % 64);
                2: d = 16'hFFE0 | (16'($urandom % 32) & 16'hFFFE);
                default: d = 16'($urandom);
            endcase
            req = k ? "R6" : (w ? "R7" : "R2");
            step(t, k, w, d, req);
        end
        finish_run();
    end
endmodule